// File: doc/BRIEF.md
# RMII Receive Framer with CRC Check

This block sits directly on the receive side of a 2-bit reduced media-independent interface running at 50 MHz and turns the dibit stream into whole bytes. It treats the carrier-sense/data-valid line as a plain data-valid signal that mirrors the far end's transmit enable, because no PHY is present on the link. Byte alignment is fixed by the first dibit sampled after data-valid rises. The least significant dibit of each byte arrives first.

A small state machine walks each burst through four phases: an optional preamble of 0x55 bytes, the start-of-frame delimiter 0xD5, the address bytes and the rest of the frame. Every byte after the delimiter, up to and including the four FCS bytes, is passed out with a one-cycle strobe. The same bytes feed a CRC-32 that runs in parallel. When data-valid falls, the block reports the frame as good or bad to the buffer logic behind it with a single pulse, and gives the byte count alongside. A burst whose preamble is malformed is ignored up to the next fall of data-valid and never reaches the buffer logic.

Top module: `rmii_rx_framer`

## Requirements
- R1: After reset, byte_valid, frame_start, frame_commit and frame_drop are all low.
- R2: Dibits are assembled four to a byte, the first dibit after crs_dv rises landing in bits [1:0] and the fourth in bits [7:6]. byte_data and byte_valid appear in the cycle after the fourth dibit is sampled. Two strobes are never adjacent.
- R3: Before the delimiter, zero to seven 0x55 bytes are accepted, followed by 0xD5. Any other byte, or an eighth 0x55, makes the block ignore the rest of the burst: no strobe, no start and no commit or drop until crs_dv falls.
- R4: Each byte from the first address byte through the last FCS byte is strobed once. frame_start is high together with the strobe of the first byte only.
- R5: In the cycle after crs_dv falls on a started frame, frame_commit pulses for one cycle if all three of these hold: the CRC-32 (reflected, polynomial 0xEDB88320, preset all ones) taken over every strobed byte leaves the residue 0xDEBB20E3, the frame holds at least 64 bytes, and it ends on a byte boundary. frame_len then gives the number of strobed bytes.
- R6: A started frame whose CRC residue is wrong gives frame_drop, not frame_commit.
- R7: A started frame of fewer than 64 bytes, counted from the address bytes through the FCS, gives frame_drop even when its CRC is right.
- R8: A started frame that ends after one to three extra dibits gives frame_drop.
- R9: Each started frame produces exactly one of frame_commit or frame_drop, never both, as a one-cycle pulse. A burst that never passed the delimiter produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crs_dv | input | 1 | Receive data-valid, high for the whole burst |
| rxd | input | 2 | Receive dibit, least significant pair first |
| byte_data | output | 8 | Assembled frame byte |
| byte_valid | output | 1 | One-cycle strobe for byte_data |
| frame_start | output | 1 | Marks the first strobed byte of a frame |
| frame_commit | output | 1 | One-cycle pulse for a good frame |
| frame_drop | output | 1 | One-cycle pulse for a bad frame |
| frame_len | output | LEN_W | Byte count of the last finished frame |

## Verification
The bench sweeps the preamble length from none to eight bytes. A machine that counted the preamble wrongly would either reject short preambles or forward a burst with one byte too many. It walks the frame length across the 64-byte minimum, where an off-by-one in the length compare would commit a 63-byte frame or drop a 64-byte one. It flips single bits in the header, the payload and the FCS, which a CRC that skipped the FCS bytes or shifted in the wrong direction would let through. It also ends frames on odd dibits, which a framer that only looked at the CRC would commit, and it sends bursts with corrupt preamble bytes, which must never reach the byte stream.

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer #(
  parameter int MIN_LEN    = 64,
  parameter int LEN_W      = 16,
  parameter int PRE_BYTES  = 7,
  parameter int ADDR_BYTES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crs_dv,
  input  logic [1:0]       rxd,
  output logic [7:0]       byte_data,
  output logic             byte_valid,
  output logic             frame_start,
  output logic             frame_commit,
  output logic             frame_drop,
  output logic [LEN_W-1:0] frame_len
);

  localparam int PC_W = $clog2(PRE_BYTES + 1);
  localparam logic [31:0] RESIDUE = 32'hDEBB20E3;
  localparam logic [31:0] POLY    = 32'hEDB88320;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SFD, S_ADDR, S_DATA, S_DISC} st_t;

  st_t              st;
  logic [1:0]       dcnt;
  logic [7:0]       sh;
  logic [PC_W-1:0]  pcnt;
  logic [LEN_W-1:0] len;
  logic [31:0]      crc;

  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  wire [7:0] nb        = {rxd, sh[7:2]};
  wire       byte_done = crs_dv && (dcnt == 2'd3);
  wire       in_frame  = (st == S_ADDR) || (st == S_DATA);
  wire       good_end  = (crc == RESIDUE) && (len >= LEN_W'(MIN_LEN)) && (dcnt == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dcnt <= '0;
      sh   <= '0;
    end else if (crs_dv) begin
      dcnt <= dcnt + 2'd1;
      sh   <= nb;
    end else begin
      dcnt <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= S_IDLE;
      pcnt         <= '0;
      len          <= '0;
      crc          <= '1;
      byte_data    <= '0;
      byte_valid   <= 1'b0;
      frame_start  <= 1'b0;
      frame_commit <= 1'b0;
      frame_drop   <= 1'b0;
      frame_len    <= '0;
    end else begin
      byte_valid   <= 1'b0;
      frame_start  <= 1'b0;
      frame_commit <= 1'b0;
      frame_drop   <= 1'b0;
      if (!crs_dv) begin
        if (in_frame) begin
          frame_commit <= good_end;
          frame_drop   <= !good_end;
          frame_len    <= len;
        end
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            st   <= S_PRE;
            pcnt <= '0;
          end
          S_PRE, S_SFD: if (byte_done) begin
            if (nb == 8'hD5) begin
              st  <= S_ADDR;
              crc <= '1;
              len <= '0;
            end else if (nb == 8'h55 && st == S_PRE) begin
              if (pcnt == PC_W'(PRE_BYTES - 1)) st <= S_SFD;
              else pcnt <= pcnt + 1'b1;
            end else begin
              st <= S_DISC;
            end
          end
          S_ADDR, S_DATA: if (byte_done) begin
            byte_data   <= nb;
            byte_valid  <= 1'b1;
            frame_start <= (len == '0);
            crc         <= crc_step(crc, nb);
            if (len != '1) len <= len + 1'b1;
            if (st == S_ADDR && len == LEN_W'(ADDR_BYTES - 1)) st <= S_DATA;
          end
          default: st <= S_DISC;
        endcase
      end
    end
  end

endmodule

// File: rtl/rmii_rx_framer_chk.sv
module rmii_rx_framer_chk (
  input logic clk,
  input logic rst_n,
  input logic crs_dv,
  input logic byte_valid,
  input logic frame_start,
  input logic frame_commit,
  input logic frame_drop
);

  p_one_verdict_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_commit && frame_drop));

  p_commit_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_commit |=> !frame_commit);

  p_drop_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |=> !frame_drop);

  p_verdict_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_commit || frame_drop) |-> !$past(crs_dv));

  p_verdict_not_with_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_commit || frame_drop) |-> !byte_valid);

  p_byte_needs_dv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |-> $past(crs_dv));

  p_byte_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  p_start_with_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> byte_valid);

endmodule

bind rmii_rx_framer rmii_rx_framer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .byte_valid(byte_valid),
  .frame_start(frame_start), .frame_commit(frame_commit), .frame_drop(frame_drop)
);

// File: tb/test_rmii_rx_framer.sv
module test_rmii_rx_framer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic [7:0] byte_data;
  logic byte_valid, frame_start, frame_commit, frame_drop;
  logic [15:0] frame_len;

  always #10 clk = ~clk;

  rmii_rx_framer i_rmii_rx_framer (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd),
    .byte_data(byte_data), .byte_valid(byte_valid), .frame_start(frame_start),
    .frame_commit(frame_commit), .frame_drop(frame_drop), .frame_len(frame_len)
  );

  int total = 0;
  int bad = 0;
  logic [7:0] fr [0:511];
  int n_bytes, n_start, n_commit, n_drop, n_mis, n_badstart, last_len;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (byte_valid) begin
      if (byte_data != fr[n_bytes]) n_mis++;
      if (frame_start != (n_bytes == 0)) n_badstart++;
      n_bytes++;
    end
    if (frame_start) n_start++;
    if (frame_commit) begin
      n_commit++;
      last_len = int'(frame_len);
    end
    if (frame_drop) n_drop++;
  end

  function automatic logic [31:0] fcs_of(input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ {24'd0, fr[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic put_byte(input logic [7:0] b);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      crs_dv = 1'b1;
      rxd = b[2*k +: 2];
    end
  endtask

  // npre preamble bytes (first one is pre0), body bytes, FCS, optional bit flip and extra dibits
  task automatic send(input int npre, input logic [7:0] pre0, input int nbody,
                      input int flip, input int extra, input int seed);
    logic [31:0] f;
    int tot;
    bit started, good;
    tot = nbody + 4;
    for (int i = 0; i < nbody; i++) fr[i] = 8'((i * 37 + seed) & 255);
    f = fcs_of(nbody);
    for (int i = 0; i < 4; i++) fr[nbody + i] = f[8*i +: 8];
    if (flip >= 0) fr[flip / 8][flip % 8] = ~fr[flip / 8][flip % 8];
    @(posedge clk);
    n_bytes = 0; n_start = 0; n_commit = 0; n_drop = 0; n_mis = 0; n_badstart = 0; last_len = -1;
    for (int i = 0; i < npre; i++) put_byte(i == 0 ? pre0 : 8'h55);
    put_byte(8'hD5);
    for (int i = 0; i < tot; i++) put_byte(fr[i]);
    for (int i = 0; i < extra; i++) begin
      @(negedge clk);
      rxd = 2'b10;
    end
    @(negedge clk);
    crs_dv = 1'b0;
    rxd = 2'b00;
    repeat (48) @(negedge clk);
    started = (npre <= 7) && (npre == 0 || pre0 == 8'h55);
    good = started && flip < 0 && extra == 0 && tot >= 64;
    chk(good ? "R5 commit count" : "R6/R7/R8 commit count", n_commit, good ? 1 : 0);
    chk(started && !good ? "R6/R7/R8 drop count" : "R9 drop count", n_drop, (started && !good) ? 1 : 0);
    chk(started ? "R4 byte count" : "R3 bytes after bad preamble", n_bytes, started ? tot : 0);
    chk("R4 start count", n_start, started ? 1 : 0);
    chk("R2 byte value mismatches", n_mis, 0);
    chk("R4 start placement", n_badstart, 0);
    if (good) chk("R5 frame_len", last_len, tot);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 byte_valid at reset", int'(byte_valid), 0);
    chk("R1 frame_start at reset", int'(frame_start), 0);
    chk("R1 frame_commit at reset", int'(frame_commit), 0);
    chk("R1 frame_drop at reset", int'(frame_drop), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R3: preamble length sweep 0..8
    for (int p = 0; p <= 8; p++) send(p, 8'h55, 60, -1, 0, p);
    // R7: length across the minimum
    for (int n = 56; n <= 66; n++) send(7, 8'h55, n, -1, 0, n + 3);
    // R6: single bit errors in header, payload and FCS
    for (int b = 0; b < 512; b += 73) send(7, 8'h55, 60, b, 0, b);
    send(7, 8'h55, 60, 511, 0, 9);
    // R8: trailing partial byte
    for (int e = 1; e <= 3; e++) send(7, 8'h55, 60, -1, e, e);
    // R3: corrupt preamble bytes
    send(3, 8'h57, 60, -1, 0, 1);
    send(2, 8'hD4, 60, -1, 0, 2);
    // long frame
    send(7, 8'h55, 300, -1, 0, 77);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule